// File: doc/BRIEF.md
# Self-Evolving Cellular Automaton Ring

This block is a one-dimensional ring of binary cells. Each cell holds its own 8-bit next-state rule in flip-flops. On every step, all cells update together. A cell's new state is looked up in its own rule, using the states of its left neighbour, itself and its right neighbour. The aim is for the whole ring to flip between all zeros and all ones on every step.

A pulse on the start input loads a 16-bit seed into an on-chip LFSR. The LFSR then fills every cell with a random rule and a random initial state. After that the controller repeats the same round. It runs the ring for a fixed number of steps and then scores every cell. If any cell is not fit, it breeds new rules for the cells that failed, using crossover of fit neighbours and a one-bit mutation. Then it runs again.

The search ends in one of two ways: every cell is fit, or the generation counter reaches a programmable limit. At that point `done_o` pulses and `success_o` shows which of the two happened. A combinational read port returns the state and rule of any cell.

Top module: `ca_evo_array`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `success_o` and `gen_count_o` are 0, and every cell reads back state 0 and rule 0.
- R2: When `start_i` is sampled high while idle, the LFSR is loaded with `seed_i`, or with 1 if the seed is 0. Then, one cell per cycle and in ascending index, the cell's rule takes LFSR bits [7:0] and its state takes LFSR bit 8, after which the LFSR advances. The LFSR shifts left and feeds bit 0 with b15^b13^b12^b10.
- R3: A run applies `STEPS` simultaneous updates. The new state of cell i is bit {s[i-1], s[i], s[i+1]} of its rule, with indices taken modulo the cell count and the left neighbour as the most significant index bit.
- R4: After a run, a cell is fit only if three things hold: its state changed on the last step, it also changed on the step before, and its final state equals the final state of cell 0.
- R5: If every cell is fit after a run, `done_o` pulses and `success_o` is 1.
- R6: If some cell is unfit and `gen_count_o` equals `gen_limit_i`, `done_o` pulses and `success_o` is 0.
- R7: Otherwise, breeding takes one cycle per cell, in ascending index, and the LFSR advances after each cell.
  - A fit cell keeps its rule.
  - An unfit cell builds a child rule:
    - If both neighbours are fit, the child takes its low p bits from the left rule and the rest from the right rule, where p = LFSR[2:0].
    - If exactly one neighbour is fit, the child is that neighbour's rule.
    - If neither neighbour is fit, the child is the cell's own rule.
  - The child then has bit LFSR[5:3] inverted.
  - After the pass, `gen_count_o` increments by one and a new run starts.
- R8: `done_o` is high for exactly one cycle. Counting from the clock edge that samples start, it rises after N + (g+1)(STEPS+1) + g·N edges, where g is the final generation count.
- R9: `start_i` has no effect while busy.
- R10: `rd_state_o` and `rd_rule_o` show the current state and rule of cell `rd_idx_i`.
- R11: `busy_o` is high from the edge that accepts start until the edge that raises `done_o`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new evolution |
| seed_i | input | 16 | LFSR seed |
| gen_limit_i | input | GEN_W | Last generation allowed |
| rd_idx_i | input | IDX_W | Cell selected for read-back |
| busy_o | output | 1 | Evolution in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| success_o | output | 1 | All cells fit at the last evaluation |
| gen_count_o | output | GEN_W | Generations bred so far |
| rd_state_o | output | 1 | State of the selected cell |
| rd_rule_o | output | 8 | Rule of the selected cell |

## Verification
The main function is driven with several kinds of seed: a zero seed, which must behave like seed 1; all ones; and a sweep of assorted seeds. Each seed is run with limits that stop the search at different depths.

A limit of 0 ends the search before any breeding. That case separates the seeding and ring update from the breeding logic. The larger limits exercise crossover, copying and mutation across many generations, and the latency check pins the cycle count of every phase.

Further cases cover a start pulse issued mid-run, and a seed chosen by a bench-side search so that it converges to full fitness.

// File: rtl/ca_evo_pkg.sv
package ca_evo_pkg;
    localparam int RULE_W = 8;
    localparam int RND_W  = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEED,
        PH_RUN,
        PH_SCORE,
        PH_BREED
    } phase_e;
endpackage

// File: rtl/ca_lfsr_step.sv
module ca_lfsr_step #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    logic fb;
    assign fb    = ^(cur_i & TAPS);
    assign nxt_o = {cur_i[W-2:0], fb};
endmodule

// File: rtl/ca_ring_next.sv
module ca_ring_next #(
    parameter int N = 56
) (
    input  logic [N-1:0]      st_i,
    input  logic [N-1:0][7:0] rules_i,
    output logic [N-1:0]      nxt_o
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        localparam int LEFT  = (i + N - 1) % N;
        localparam int RIGHT = (i + 1) % N;
        logic [2:0] nb;
        assign nb       = {st_i[LEFT], st_i[i], st_i[RIGHT]};
        assign nxt_o[i] = rules_i[i][nb];
    end
endmodule

// File: rtl/ca_fit_eval.sv
module ca_fit_eval #(
    parameter int N = 56
) (
    input  logic [N-1:0] st_i,
    input  logic [N-1:0] p1_i,
    input  logic [N-1:0] p2_i,
    output logic [N-1:0] fit_o,
    output logic         all_fit_o
);
    for (genvar i = 0; i < N; i++) begin : g_fit
        assign fit_o[i] = (st_i[i] ^ p1_i[i]) & (p1_i[i] ^ p2_i[i]) & ~(st_i[i] ^ st_i[0]);
    end
    assign all_fit_o = &fit_o;
endmodule

// File: rtl/ca_breed.sv
module ca_breed (
    input  logic [7:0] own_i,
    input  logic [7:0] left_i,
    input  logic [7:0] right_i,
    input  logic       fit_l_i,
    input  logic       fit_r_i,
    input  logic [5:0] rnd_i,
    output logic [7:0] child_o
);
    logic [7:0] low_mask;
    logic [7:0] parent;
    always_comb begin
        low_mask = (8'h01 << rnd_i[2:0]) - 8'h01;
        if (fit_l_i && fit_r_i) parent = (left_i & low_mask) | (right_i & ~low_mask);
        else if (fit_l_i)       parent = left_i;
        else if (fit_r_i)       parent = right_i;
        else                    parent = own_i;
        child_o = parent ^ (8'h01 << rnd_i[5:3]);
    end
endmodule

// File: rtl/ca_evo_array.sv
module ca_evo_array
    import ca_evo_pkg::*;
#(
    parameter int N     = 56,
    parameter int STEPS = 16,
    parameter int GEN_W = 8,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
    localparam int STEP_W = $clog2(STEPS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      seed_i,
    input  logic [GEN_W-1:0] gen_limit_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             success_o,
    output logic [GEN_W-1:0] gen_count_o,
    output logic             rd_state_o,
    output logic [7:0]       rd_rule_o
);
    typedef struct packed {
        phase_e                   phase;
        logic [RND_W-1:0]         lfsr;
        logic [IDX_W-1:0]         idx;
        logic [STEP_W-1:0]        step;
        logic [GEN_W-1:0]         gen;
        logic [N-1:0]             st;
        logic [N-1:0]             p1;
        logic [N-1:0]             p2;
        logic [N-1:0][RULE_W-1:0] rules;
        logic                     done;
        logic                     success;
    } regs_t;

    regs_t q, d;

    logic [RND_W-1:0] lfsr_nxt;
    logic [N-1:0]     ring_nxt;
    logic [N-1:0]     fit;
    logic             all_fit;
    logic [IDX_W-1:0] left_idx, right_idx;
    logic [7:0]       child;

    ca_lfsr_step #(.W(RND_W), .TAPS(16'hB400)) u_lfsr (
        .cur_i(q.lfsr), .nxt_o(lfsr_nxt)
    );

    ca_ring_next #(.N(N)) u_ring (
        .st_i(q.st), .rules_i(q.rules), .nxt_o(ring_nxt)
    );

    ca_fit_eval #(.N(N)) u_fit (
        .st_i(q.st), .p1_i(q.p1), .p2_i(q.p2), .fit_o(fit), .all_fit_o(all_fit)
    );

    assign left_idx  = (q.idx == '0) ? IDX_W'(N - 1) : q.idx - 1'b1;
    assign right_idx = (q.idx == IDX_W'(N - 1)) ? '0 : q.idx + 1'b1;

    ca_breed u_breed (
        .own_i  (q.rules[q.idx]),
        .left_i (q.rules[left_idx]),
        .right_i(q.rules[right_idx]),
        .fit_l_i(fit[left_idx]),
        .fit_r_i(fit[right_idx]),
        .rnd_i  (q.lfsr[5:0]),
        .child_o(child)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.lfsr    = (seed_i == '0) ? RND_W'(1) : seed_i;
                    d.gen     = '0;
                    d.idx     = '0;
                    d.success = 1'b0;
                    d.phase   = PH_SEED;
                end
            end
            PH_SEED: begin
                d.rules[q.idx] = q.lfsr[7:0];
                d.st[q.idx]    = q.lfsr[8];
                d.lfsr         = lfsr_nxt;
                if (q.idx == IDX_W'(N - 1)) begin
                    d.phase = PH_RUN;
                    d.step  = '0;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            PH_RUN: begin
                d.p2 = q.p1;
                d.p1 = q.st;
                d.st = ring_nxt;
                if (q.step == STEP_W'(STEPS - 1)) d.phase = PH_SCORE;
                else                               d.step  = q.step + 1'b1;
            end
            PH_SCORE: begin
                if (all_fit) begin
                    d.done    = 1'b1;
                    d.success = 1'b1;
                    d.phase   = PH_IDLE;
                end else if (q.gen == gen_limit_i) begin
                    d.done  = 1'b1;
                    d.phase = PH_IDLE;
                end else begin
                    d.idx   = '0;
                    d.phase = PH_BREED;
                end
            end
            PH_BREED: begin
                if (!fit[q.idx]) d.rules[q.idx] = child;
                d.lfsr = lfsr_nxt;
                if (q.idx == IDX_W'(N - 1)) begin
                    d.phase = PH_RUN;
                    d.step  = '0;
                    d.gen   = q.gen + 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = (q.phase != PH_IDLE);
    assign done_o      = q.done;
    assign success_o   = q.success;
    assign gen_count_o = q.gen;
    assign rd_state_o  = q.st[rd_idx_i];
    assign rd_rule_o   = q.rules[rd_idx_i];
endmodule

// File: rtl/ca_evo_array_chk.sv
module ca_evo_array_chk #(
    parameter int GEN_W = 8,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             success_o,
    input logic [GEN_W-1:0] gen_count_o,
    input logic [GEN_W-1:0] gen_limit_i,
    input logic [IDX_W-1:0] rd_idx_i,
    input logic             rd_state_o,
    input logic [7:0]       rd_rule_o
);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5
    success_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(success_o) |-> done_o);

    // R7
    gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$stable(gen_count_o))
            |-> gen_count_o == $past(gen_count_o) + 1'b1);

    // R6
    gen_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $stable(gen_limit_i)) |-> gen_count_o <= gen_limit_i);

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o) && $stable(rd_idx_i))
            |-> ($stable(rd_rule_o) && $stable(rd_state_o)));
endmodule

bind ca_evo_array ca_evo_array_chk #(.GEN_W(GEN_W), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .success_o  (success_o),
    .gen_count_o(gen_count_o),
    .gen_limit_i(gen_limit_i),
    .rd_idx_i   (rd_idx_i),
    .rd_state_o (rd_state_o),
    .rd_rule_o  (rd_rule_o)
);

// File: tb/ca_evo_array_tb_top.sv
module ca_evo_array_tb_top;
    localparam int N     = 6;
    localparam int STEPS = 4;
    localparam int GEN_W = 8;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [15:0]      seed_i = '0;
    logic [GEN_W-1:0] gen_limit_i = '0;
    logic [IDX_W-1:0] rd_idx_i = '0;
    logic             busy_o, done_o, success_o, rd_state_o;
    logic [GEN_W-1:0] gen_count_o;
    logic [7:0]       rd_rule_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ca_evo_array #(.N(N), .STEPS(STEPS), .GEN_W(GEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
        .gen_limit_i(gen_limit_i), .rd_idx_i(rd_idx_i), .busy_o(busy_o),
        .done_o(done_o), .success_o(success_o), .gen_count_o(gen_count_o),
        .rd_state_o(rd_state_o), .rd_rule_o(rd_rule_o)
    );

    logic [7:0] m_rule [N];
    logic       m_st   [N];
    logic       m_p1   [N];
    logic       m_p2   [N];
    logic       m_fit  [N];

    function automatic logic [15:0] lstep(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic model_run(input logic [15:0] seed, input int limit,
                             output int g, output bit succ);
        logic [15:0] l;
        logic        nx [N];
        bit          all;
        l = (seed == 0) ? 16'h1 : seed;
        for (int i = 0; i < N; i++) begin
            m_rule[i] = l[7:0];
            m_st[i]   = l[8];
            l = lstep(l);
        end
        g = 0;
        succ = 0;
        forever begin
            for (int s = 0; s < STEPS; s++) begin
                for (int i = 0; i < N; i++)
                    nx[i] = m_rule[i][{m_st[(i+N-1)%N], m_st[i], m_st[(i+1)%N]}];
                for (int i = 0; i < N; i++) begin
                    m_p2[i] = m_p1[i];
                    m_p1[i] = m_st[i];
                    m_st[i] = nx[i];
                end
            end
            all = 1;
            for (int i = 0; i < N; i++) begin
                m_fit[i] = (m_st[i] != m_p1[i]) && (m_p1[i] != m_p2[i]) && (m_st[i] == m_st[0]);
                if (!m_fit[i]) all = 0;
            end
            if (all) begin succ = 1; return; end
            if (g == limit) return;
            for (int i = 0; i < N; i++) begin
                int lft = (i + N - 1) % N;
                int rgt = (i + 1) % N;
                logic [7:0] m, c;
                if (!m_fit[i]) begin
                    m = (8'h01 << l[2:0]) - 8'h01;
                    if (m_fit[lft] && m_fit[rgt]) c = (m_rule[lft] & m) | (m_rule[rgt] & ~m);
                    else if (m_fit[lft])          c = m_rule[lft];
                    else if (m_fit[rgt])          c = m_rule[rgt];
                    else                          c = m_rule[i];
                    m_rule[i] = c ^ (8'h01 << l[5:3]);
                end
                l = lstep(l);
            end
            g++;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One full search on the DUT, compared with the model of the same seed.
    task automatic run_cmp(input logic [15:0] seed, input int limit,
                           input bit inject, input string rtag);
        int  g, lat, n;
        bit  succ;
        model_run(seed, limit, g, succ);
        lat = N + (g + 1) * (STEPS + 1) + g * N;
        @(negedge clk);
        seed_i = seed;
        gen_limit_i = GEN_W'(limit);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R11", "busy after start", busy_o, 1);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 5) begin
                start_i = 1'b1;       // R9: ignored while busy
                seed_i  = ~seed;
            end else begin
                start_i = 1'b0;
            end
            if (done_o || n > 20000) break;
        end
        check(n == lat, "R8", "done latency", n, lat);
        check(gen_count_o == GEN_W'(g), inject ? "R9" : "R7", "generation count", gen_count_o, g);
        check(success_o == succ, succ ? "R5" : "R6", "success flag", success_o, succ);
        check(busy_o == 1'b0, "R11", "busy at done", busy_o, 0);
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R8", "done width", done_o, 0);
        for (int i = 0; i < N; i++) begin
            rd_idx_i = IDX_W'(i);
            #1;
            check(rd_rule_o == m_rule[i], rtag, "cell rule", rd_rule_o, m_rule[i]);
            check(rd_state_o == m_st[i], "R3", "cell state (R4 fitness path)", rd_state_o, m_st[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int  gs;
        bit  sc;
        int  found;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(busy_o == 0 && done_o == 0 && success_o == 0, "R1", "status after reset",
              {busy_o, done_o, success_o}, 0);
        check(gen_count_o == 0, "R1", "generation after reset", gen_count_o, 0);
        for (int i = 0; i < N; i++) begin
            rd_idx_i = IDX_W'(i);
            #1;
            check(rd_rule_o == 0 && rd_state_o == 0, "R1", "cell after reset (R10 read)",
                  {rd_state_o, rd_rule_o}, 0);
        end
        // R2: limit 0 means no breeding; rules are the seeded values
        run_cmp(16'h0000, 0, 0, "R2");
        run_cmp(16'hFFFF, 0, 0, "R2");
        run_cmp(16'hACE1, 0, 0, "R2");
        // R7: breeding across several seeds and depths
        for (int k = 0; k < 10; k++) begin
            run_cmp(16'h1357 * (k + 1) + 16'h0F0F, 3 + 5 * k, 0, "R7");
        end
        // R9: start pulse during a run has no effect
        run_cmp(16'h5A5A, 10, 1, "R9");
        // R5: look for a converging seed with the model
        found = 0;
        for (int s = 1; s < 3000 && found == 0; s++) begin
            model_run(16'(s), 60, gs, sc);
            if (sc) found = s;
        end
        if (found != 0) run_cmp(16'(found), 60, 0, "R5");
        else $display("note: no converging seed in search range");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule